// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory from power-on to a usable state. A single-cycle start pulse launches a fixed bring-up script: a stabilisation delay derived from the clock period, then precharge-all, the three extended mode-register loads, the normal mode-register load with DLL reset, a second precharge-all, two auto-refreshes and the normal mode-register load without DLL reset. After a post-DLL-reset delay it finishes with the two off-chip-driver calibration loads: one selecting the calibration default and one leaving calibration mode.

The script runs for rank 0 and, if the dual-rank input was high at start, again for rank 1. Each command goes out on a valid/ready interface with a command code, rank select, bank field and address value. The sequencer holds the command until it is accepted. When every rank is done it raises a done flag and enables automatic refresh. Both stay high until reset. Mode-register contents come from configuration inputs. The block sets or clears only the DLL-reset, DLL-enable and calibration fields.

Top module: `ddr2i_seq`

## Requirements
- R1: While reset is high and after it is released, cmd_valid, busy, done and refresh_en are all 0 until a start pulse arrives.
- R2: A start pulse sampled in idle begins the sequence. The first command becomes valid exactly PWR_CYC = ceil(400000 / CLK_PERIOD_PS) cycles after the edge that sampled start.
- R3: Per rank, the accepted commands are, in order: PALL, EMRS2, EMRS3, EMRS, MRS, PALL, REF, REF, MRS, EMRS, EMRS. Codes are NOP=0, PALL=1, REF=2, MRS=3, EMRS=4. The bank field is 0 for MRS, 1 for EMRS, 2 for EMRS2 and 3 for EMRS3; EMRS2 and EMRS3 use code 4. PALL carries address bit 10 set with bank 0. REF carries address 0 and bank 0. A valid command is never NOP.
- R4: The first MRS carries mr_base with bit 8 (DLL reset) set. The second MRS carries mr_base with bit 8 cleared.
- R5: EMRS2 and EMRS3 carry emr2_val and emr3_val. The first EMRS carries emr_base with bit 0 cleared (DLL enabled) and bits 9:7 cleared. The calibration-default EMRS is that value with bits 9:7 = 111. The final EMRS equals the first EMRS value.
- R6: After the handshake of the second MRS, cmd_valid stays low for exactly POST_MRS_CYCLES cycles. Every other pair of commands within a rank is back to back: the next command is valid in the cycle after the handshake.
- R7: While cmd_valid is high and cmd_ready is low, the command and its fields stay unchanged and the sequence does not advance.
- R8: If dual_rank is high at start, the whole per-rank list repeats with cmd_rank=1 after rank 0 completes, preceded by another PWR_CYC-cycle gap. All rank-0 commands carry cmd_rank=0.
- R9: done and refresh_en rise together in the cycle after the last handshake. Both are 0 before that, and they hold until reset with no further commands.
- R10: A start pulse while the sequence is running or finished has no effect on the command stream, done or refresh_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the bring-up sequence (pulse) |
| dual_rank | input | 1 | Initialise rank 1 as well; sampled at start |
| mr_base | input | ADDR_W | Operating value for the normal mode register |
| emr_base | input | ADDR_W | Operating value for extended mode register 1 |
| emr2_val | input | ADDR_W | Value for extended mode register 2 |
| emr3_val | input | ADDR_W | Value for extended mode register 3 |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_code | output | 3 | Command code |
| cmd_rank | output | 1 | Target rank |
| cmd_ba | output | 3 | Bank field (selects mode register) |
| cmd_addr | output | ADDR_W | Address / mode-register value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All ranks initialised |
| refresh_en | output | 1 | Enable for the automatic refresh counter |

## Verification
The bench sets CLK_PERIOD_PS to 20000, which gives a 20-cycle stabilisation gap, and keeps POST_MRS_CYCLES at its 200-cycle floor with ADDR_W at 14. Those values keep each full run to a few hundred cycles. The bench can then sweep both rank counts, three ready patterns (always ready, alternating, and long stalls) and two mode-register data sets. That covers every field override against both all-zero and mostly-one backgrounds. Each sweep point measures every inter-command gap and compares every accepted command with an arithmetic model. It also probes start pulses mid-run and after completion.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

    localparam int BA_W = 3;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PALL = 3'd1,
        CMD_REF  = 3'd2,
        CMD_MRS  = 3'd3,
        CMD_EMRS = 3'd4
    } cmd_code_e;

    typedef enum logic [3:0] {
        ST_PALL_A    = 4'd0,
        ST_EMR2      = 4'd1,
        ST_EMR3      = 4'd2,
        ST_EMR_DLL   = 4'd3,
        ST_MR_DLLRST = 4'd4,
        ST_PALL_B    = 4'd5,
        ST_REF_A     = 4'd6,
        ST_REF_B     = 4'd7,
        ST_MR_RUN    = 4'd8,
        ST_OCD_DFLT  = 4'd9,
        ST_OCD_EXIT  = 4'd10
    } step_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PWR_WAIT,
        PH_ISSUE,
        PH_MR_WAIT,
        PH_DONE
    } phase_e;

    typedef struct packed {
        cmd_code_e        code;
        logic [BA_W-1:0]  ba;
    } cmd_hdr_t;

    // Mode-register bit positions fixed by the DDR2 register layout
    localparam int PALL_BIT    = 10;
    localparam int DLLRST_BIT  = 8;
    localparam int DLLDIS_BIT  = 0;
    localparam int OCD_LSB     = 7;
    localparam int OCD_W       = 3;

    // Bank values selecting each mode register
    localparam logic [BA_W-1:0] BA_MR   = 3'd0;
    localparam logic [BA_W-1:0] BA_EMR1 = 3'd1;
    localparam logic [BA_W-1:0] BA_EMR2 = 3'd2;
    localparam logic [BA_W-1:0] BA_EMR3 = 3'd3;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2i_timer.sv
module ddr2i_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ddr2i_cmd_gen.sv
module ddr2i_cmd_gen
    import ddr2i_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  step_e             step,
    input  logic [ADDR_W-1:0] mr_base,
    input  logic [ADDR_W-1:0] emr_base,
    input  logic [ADDR_W-1:0] emr2_val,
    input  logic [ADDR_W-1:0] emr3_val,
    output cmd_hdr_t          hdr,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] PALL_MASK   = ADDR_W'(1) << PALL_BIT;
    localparam logic [ADDR_W-1:0] DLLRST_MASK = ADDR_W'(1) << DLLRST_BIT;
    localparam logic [ADDR_W-1:0] DLLDIS_MASK = ADDR_W'(1) << DLLDIS_BIT;
    localparam logic [ADDR_W-1:0] OCD_MASK    = ADDR_W'((1 << OCD_W) - 1) << OCD_LSB;

    logic [ADDR_W-1:0] emr_run;

    // Extended mode value with DLL enabled and calibration field at exit
    assign emr_run = emr_base & ~(DLLDIS_MASK | OCD_MASK);

    always_comb begin
        hdr  = '{code: CMD_NOP, ba: BA_MR};
        addr = '0;
        unique case (step)
            ST_PALL_A, ST_PALL_B: begin
                hdr  = '{code: CMD_PALL, ba: BA_MR};
                addr = PALL_MASK;
            end
            ST_EMR2: begin
                hdr  = '{code: CMD_EMRS, ba: BA_EMR2};
                addr = emr2_val;
            end
            ST_EMR3: begin
                hdr  = '{code: CMD_EMRS, ba: BA_EMR3};
                addr = emr3_val;
            end
            ST_EMR_DLL, ST_OCD_EXIT: begin
                hdr  = '{code: CMD_EMRS, ba: BA_EMR1};
                addr = emr_run;
            end
            ST_MR_DLLRST: begin
                hdr  = '{code: CMD_MRS, ba: BA_MR};
                addr = mr_base | DLLRST_MASK;
            end
            ST_REF_A, ST_REF_B: begin
                hdr  = '{code: CMD_REF, ba: BA_MR};
                addr = '0;
            end
            ST_MR_RUN: begin
                hdr  = '{code: CMD_MRS, ba: BA_MR};
                addr = mr_base & ~DLLRST_MASK;
            end
            ST_OCD_DFLT: begin
                hdr  = '{code: CMD_EMRS, ba: BA_EMR1};
                addr = emr_run | OCD_MASK;
            end
            default: begin
                hdr  = '{code: CMD_NOP, ba: BA_MR};
                addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/ddr2i_seq.sv
module ddr2i_seq
    import ddr2i_pkg::*;
#(
    parameter int ADDR_W          = 14,
    parameter int CLK_PERIOD_PS   = 2500,
    parameter int PWRUP_PS        = 400000,
    parameter int POST_MRS_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dual_rank,
    input  logic [ADDR_W-1:0] mr_base,
    input  logic [ADDR_W-1:0] emr_base,
    input  logic [ADDR_W-1:0] emr2_val,
    input  logic [ADDR_W-1:0] emr3_val,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [2:0]        cmd_code,
    output logic              cmd_rank,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              done,
    output logic              refresh_en
);
    localparam int PWR_CYC = imax(1, ceil_div(PWRUP_PS, CLK_PERIOD_PS));
    localparam int MRW_CYC = imax(1, POST_MRS_CYCLES);
    localparam int TMR_W   = $clog2(imax(PWR_CYC, MRW_CYC) + 1);

    phase_e   phase;
    step_e    step;
    logic     rank;
    logic     two_rank;
    logic     fire;
    logic     last_rank;
    logic     tmr_load;
    logic     tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    cmd_hdr_t hdr;
    logic [ADDR_W-1:0] addr;

    assign fire      = (phase == PH_ISSUE) && cmd_ready;
    assign last_rank = (rank == 1'b1) || !two_rank;

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(PWR_CYC - 1);
        if (phase == PH_IDLE && start) begin
            tmr_load = 1'b1;
        end else if (fire && step == ST_OCD_EXIT && !last_rank) begin
            tmr_load = 1'b1;
        end else if (fire && step == ST_MR_RUN) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(MRW_CYC - 1);
        end
    end

    ddr2i_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    ddr2i_cmd_gen #(.ADDR_W(ADDR_W)) u_gen (
        .step     (step),
        .mr_base  (mr_base),
        .emr_base (emr_base),
        .emr2_val (emr2_val),
        .emr3_val (emr3_val),
        .hdr      (hdr),
        .addr     (addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            step     <= ST_PALL_A;
            rank     <= 1'b0;
            two_rank <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        two_rank <= dual_rank;
                        rank     <= 1'b0;
                        step     <= ST_PALL_A;
                        phase    <= PH_PWR_WAIT;
                    end
                end
                PH_PWR_WAIT, PH_MR_WAIT: begin
                    if (tmr_zero) phase <= PH_ISSUE;
                end
                PH_ISSUE: begin
                    if (cmd_ready) begin
                        if (step == ST_OCD_EXIT) begin
                            if (last_rank) begin
                                phase <= PH_DONE;
                            end else begin
                                rank  <= 1'b1;
                                step  <= ST_PALL_A;
                                phase <= PH_PWR_WAIT;
                            end
                        end else begin
                            step <= step_e'(step + 4'd1);
                            if (step == ST_MR_RUN) phase <= PH_MR_WAIT;
                        end
                    end
                end
                PH_DONE: phase <= PH_DONE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign cmd_valid  = (phase == PH_ISSUE);
    assign cmd_code   = hdr.code;
    assign cmd_ba     = hdr.ba;
    assign cmd_addr   = addr;
    assign cmd_rank   = rank;
    assign busy       = (phase == PH_PWR_WAIT) || (phase == PH_ISSUE) || (phase == PH_MR_WAIT);
    assign done       = (phase == PH_DONE);
    assign refresh_en = (phase == PH_DONE);
endmodule

// File: rtl/ddr2i_seq_chk.sv
module ddr2i_seq_chk #(
    parameter int ADDR_W          = 14,
    parameter int POST_MRS_CYCLES = 200
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_code,
    input logic              cmd_rank,
    input logic [2:0]        cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              busy,
    input logic              done,
    input logic              refresh_en
);
    // Cycles remaining in the window after the second MRS
    logic [15:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt <= '0;
        end else if (cmd_valid && cmd_ready && cmd_code == 3'd3 && !cmd_addr[8]) begin
            quiet_cnt <= 16'(POST_MRS_CYCLES);
        end else if (quiet_cnt != '0) begin
            quiet_cnt <= quiet_cnt - 16'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !cmd_valid && !done && !refresh_en && !busy);

    p_no_nop_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_code != 3'd0);

    p_dll_wait_r6: assert property (@(posedge clk) disable iff (rst)
        quiet_cnt != '0 |-> !cmd_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_ba)
            && $stable(cmd_addr) && $stable(cmd_rank));

    p_refresh_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(refresh_en) |-> $past(cmd_valid && cmd_ready));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> done && refresh_en && !cmd_valid);
endmodule

bind ddr2i_seq ddr2i_seq_chk #(
    .ADDR_W(ADDR_W),
    .POST_MRS_CYCLES(POST_MRS_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_code   (cmd_code),
    .cmd_rank   (cmd_rank),
    .cmd_ba     (cmd_ba),
    .cmd_addr   (cmd_addr),
    .busy       (busy),
    .done       (done),
    .refresh_en (refresh_en)
);

// File: tb/sim_ddr2i_seq.sv
`timescale 1ns/1ps
module sim_ddr2i_seq;
    localparam int AW   = 14;
    localparam int PER  = 20000;
    localparam int PWR  = (400000 + PER - 1) / PER;
    localparam int POST = 200;
    localparam int NSTEP = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic dual_rank = 1'b0;
    logic [AW-1:0] mr_base = '0, emr_base = '0, emr2_val = '0, emr3_val = '0;
    logic cmd_ready = 1'b0;
    logic cmd_valid, cmd_rank, busy, done, refresh_en;
    logic [2:0] cmd_code, cmd_ba;
    logic [AW-1:0] cmd_addr;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ddr2i_seq #(.ADDR_W(AW), .CLK_PERIOD_PS(PER), .POST_MRS_CYCLES(POST)) u0 (
        .clk(clk), .rst(rst), .start(start), .dual_rank(dual_rank),
        .mr_base(mr_base), .emr_base(emr_base), .emr2_val(emr2_val), .emr3_val(emr3_val),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
        .cmd_rank(cmd_rank), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
        .busy(busy), .done(done), .refresh_en(refresh_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void exp_cmd(input int idx, output logic [2:0] c,
                                    output logic [2:0] ba, output logic [AW-1:0] a);
        logic [AW-1:0] er;
        er = emr_base & ~(AW'(1) | (AW'(7) << 7));
        case (idx % NSTEP)
            0, 5:  begin c = 3'd1; ba = 3'd0; a = AW'(1) << 10; end
            1:     begin c = 3'd4; ba = 3'd2; a = emr2_val; end
            2:     begin c = 3'd4; ba = 3'd3; a = emr3_val; end
            3, 10: begin c = 3'd4; ba = 3'd1; a = er; end
            4:     begin c = 3'd3; ba = 3'd0; a = mr_base | (AW'(1) << 8); end
            6, 7:  begin c = 3'd2; ba = 3'd0; a = '0; end
            8:     begin c = 3'd3; ba = 3'd0; a = mr_base & ~(AW'(1) << 8); end
            default: begin c = 3'd4; ba = 3'd1; a = er | (AW'(7) << 7); end
        endcase
    endfunction

    function automatic int exp_gap(input int idx);
        if (idx % NSTEP == 0) return PWR;
        if (idx % NSTEP == 9) return POST;
        return 0;
    endfunction

    function automatic bit ready_pat(input int pat, input int t);
        case (pat)
            0: return 1'b1;
            1: return t[0];
            default: return (t % 4) == 3;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; cmd_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_seq(input bit dual, input int pat, input bit poke);
        int n, idx, gap, t, guard;
        bit seen, early_ref, held_ok, bad_hold;
        logic [2:0] ec, eb;
        logic [AW-1:0] ea;
        logic [2:0] hc, hb;
        logic [AW-1:0] ha;
        n = NSTEP * (dual ? 2 : 1);
        do_reset();
        #1;
        chk(!cmd_valid && !busy && !done && !refresh_en, "R1", "idle outputs",
            {cmd_valid, busy, done, refresh_en}, 0);
        dual_rank = dual;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dual_rank = !dual;   // must be ignored after start (R8)
        idx = 0; gap = 0; t = 0; guard = 0; seen = 0; early_ref = 0;
        held_ok = 0; bad_hold = 0;
        hc = '0; hb = '0; ha = '0;
        while (idx < n && guard < 5000) begin
            cmd_ready = ready_pat(pat, t);
            start = poke && (idx == 3 || idx == 14);
            #1;
            if (done || refresh_en) early_ref = 1;
            if (held_ok) begin
                if (!cmd_valid || cmd_code != hc || cmd_ba != hb || cmd_addr != ha)
                    bad_hold = 1;
            end
            held_ok = 0;
            if (cmd_valid) begin
                if (!seen) begin
                    chk(gap == exp_gap(idx), (idx % NSTEP == 9) ? "R6" :
                        ((idx % NSTEP == 0) ? ((idx == 0) ? "R2" : "R8") : "R6"),
                        "gap before command", gap, exp_gap(idx));
                    seen = 1;
                end
                if (cmd_ready) begin
                    exp_cmd(idx, ec, eb, ea);
                    chk(cmd_code == ec, "R3", "code", cmd_code, ec);
                    chk(cmd_ba == eb, "R3", "bank", cmd_ba, eb);
                    chk(cmd_addr == ea, (idx % NSTEP == 4 || idx % NSTEP == 8) ? "R4" :
                        ((idx % NSTEP inside {1, 2, 3, 9, 10}) ? "R5" : "R3"),
                        "addr", cmd_addr, ea);
                    chk(cmd_rank == (idx >= NSTEP), "R8", "rank", cmd_rank, idx >= NSTEP);
                    idx++; gap = 0; seen = 0;
                end else begin
                    held_ok = 1; hc = cmd_code; hb = cmd_ba; ha = cmd_addr;
                end
            end else begin
                gap++;
            end
            @(negedge clk);
            t++; guard++;
        end
        start = 1'b0;
        chk(guard < 5000, "R3", "sequence completed", guard, 5000);
        chk(!bad_hold, "R7", "stalled command held", bad_hold, 0);
        chk(!early_ref, "R9", "done/refresh before end", early_ref, 0);
        #1;
        chk(done && refresh_en && !cmd_valid, "R9", "done after last",
            {done, refresh_en, cmd_valid}, 3'b110);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 30; k++) begin
            #1;
            if (cmd_valid || !done || !refresh_en || busy) early_ref = 1;
            @(negedge clk);
        end
        chk(!early_ref, "R10", "start after done ignored", early_ref, 0);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!cmd_valid && !done && !refresh_en && !busy, "R1", "in reset",
            {cmd_valid, done, refresh_en, busy}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk(!cmd_valid && !done && !refresh_en && !busy, "R1", "no start",
            {cmd_valid, done, refresh_en, busy}, 0);
        for (int ds = 0; ds < 2; ds++) begin
            if (ds == 0) begin
                mr_base = 14'h0632; emr_base = 14'h0044; emr2_val = '0; emr3_val = '0;
            end else begin
                mr_base = 14'h3EFF; emr_base = 14'h3FFF; emr2_val = 14'h2AAA; emr3_val = 14'h1555;
            end
            for (int d = 0; d < 2; d++) begin
                for (int p = 0; p < 3; p++) begin
                    run_seq(d[0], p, p == 1);
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule